// File: doc/BRIEF.md
# CAN Acceptance Filter Bank

This block sits after the bit-level receiver of a CAN controller and decides whether each completed frame goes into the receive queue. It holds a bank of filter/mask slots, eight by default. Each slot holds a comparison key made of the frame-format bit, a 29-bit identifier and the first two payload bytes, plus a mask of the same shape. A mask bit of one turns the matching key bit into a don't-care. The bank checks all slots at once. When filtering is on, a frame is kept if any slot matches it. When filtering is off, every valid frame is kept.

Kept frames go into a receive FIFO, eight entries deep by default. When the FIFO is full, a kept frame is discarded, the stored frames stay as they are, and a sticky overflow flag is raised. A separate latest-frame buffer always takes the most recent frame, whatever the filters decide, so the host can still see traffic that was rejected. Filter and mask contents can only be changed while the controller is in initialization mode.

Frames arrive as one parallel word with a one-cycle valid strobe. The per-frame decision outputs are registered and appear on the cycle after the strobe.

Top module: `can_accept_bank`

## Requirements
- R1: After synchronous reset the FIFO is empty (`fifo_cnt_o`=0, `rd_valid_o`=0), and `acc_o`, `push_o`, `hit_o`, `ovf_o` and `tmp_valid_o` are all 0.
- R2: Frame words use the layout {ide[50], rtr[49], id[48:20], dlc[19:16], byte0[15:8], byte1[7:0]}. Key and mask words use {ide[45], id[44:16], byte0[15:8], byte1[7:0]}. A key bit takes part in the comparison only when its mask bit is 0.
- R3: With `filt_en`=0, every frame strobed by `frm_valid` is accepted (`acc_o`=1).
- R4: With `filt_en`=1, a frame is accepted only if at least one slot matches it. `hit_o[k]` is 1 exactly when slot k matches the strobed frame, whatever the value of `filt_en`.
- R5: The frame's ide bit must equal the slot's key ide bit, and this bit cannot be masked. For a standard frame (ide=0), only id[10:0] is compared and id[28:11] is ignored.
- R6: A payload byte k (k=0,1) is present only when rtr=0 and dlc>k. Each bit of an absent byte counts as a mismatch unless its mask bit is 1.
- R7: An accepted frame is written to the FIFO when it is not full (`push_o`=1). Frames are read oldest first: `rd_frame_o` shows the oldest entry, and `rd_pop` removes it.
- R8: When the FIFO holds DEPTH frames, an accepted frame is discarded (`push_o`=0) and the stored frames are unchanged. A pop in the same cycle does not make room for that frame.
- R9: `ovf_o` is set when a frame is discarded by R8 and cleared by `ovf_clr`. If both happen in the same cycle, setting wins.
- R10: Every strobed frame, accepted or rejected, is copied to `tmp_frame_o`, and `tmp_valid_o` becomes 1.
- R11: A write with `cfg_we`=1 updates slot `cfg_idx` (its mask when `cfg_mask_sel`=1, otherwise its key) only while `init_mode`=1. At all other times the write is ignored.
- R12: `acc_o`, `push_o` and `hit_o` are one-cycle pulses that appear in the cycle after the `frm_valid` strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_mode | input | 1 | Controller is in initialization mode; enables slot writes |
| cfg_we | input | 1 | Slot write strobe |
| cfg_idx | input | 3 | Slot selected for the write |
| cfg_mask_sel | input | 1 | 1 writes the mask, 0 writes the key |
| cfg_word | input | 46 | Key or mask value |
| filt_en | input | 1 | Global filtering enable |
| frm_valid | input | 1 | One-cycle strobe for a completed frame |
| frm_i | input | 51 | Parsed frame fields |
| rd_pop | input | 1 | Remove the oldest FIFO entry |
| ovf_clr | input | 1 | Clear the overflow flag |
| acc_o | output | 1 | Frame passed the accept rule |
| push_o | output | 1 | Frame was written to the FIFO |
| hit_o | output | 8 | Per-slot match vector |
| ovf_o | output | 1 | Sticky overflow flag |
| fifo_cnt_o | output | 4 | Number of frames in the FIFO |
| rd_valid_o | output | 1 | FIFO not empty |
| rd_frame_o | output | 51 | Oldest FIFO frame |
| tmp_valid_o | output | 1 | Latest-frame buffer has been written |
| tmp_frame_o | output | 51 | Latest received frame |

## Verification
The bench uses the default eight slots and eight FIFO entries. With eight entries, the full condition is reached after a handful of frames. That makes it cheap to test the drop on full, the overflow flag and its set-over-clear priority, and a pop arriving in the same cycle as a frame on a full FIFO, followed by a full in-order drain. Four of the eight slots are programmed to cover exact, partly masked, extended-format and two-byte payload keys. The remaining four keep their reset contents, so the effect of missing payload bytes on unmasked slots is also tested.

// File: rtl/can_acc_pkg.sv
package can_acc_pkg;

    localparam int ID_W     = 29;
    localparam int STD_ID_W = 11;
    localparam int DLC_W    = 4;
    localparam int BYTE_W   = 8;

    typedef struct packed {
        logic              ide;
        logic              rtr;
        logic [ID_W-1:0]   id;
        logic [DLC_W-1:0]  dlc;
        logic [BYTE_W-1:0] b0;
        logic [BYTE_W-1:0] b1;
    } rx_frame_t;

    typedef struct packed {
        logic              ide;
        logic [ID_W-1:0]   id;
        logic [BYTE_W-1:0] b0;
        logic [BYTE_W-1:0] b1;
    } flt_key_t;

    localparam int FRAME_W = $bits(rx_frame_t);
    localparam int KEY_W   = $bits(flt_key_t);

    typedef enum logic [1:0] {
        DEC_IDLE,
        DEC_REJECT,
        DEC_DROP_FULL,
        DEC_STORE
    } dec_e;

    // Identifier bits that take part in the comparison for a given format.
    function automatic logic [ID_W-1:0] id_span(input logic ide);
        logic [ID_W-1:0] s;
        s = '0;
        s[STD_ID_W-1:0] = '1;
        return ide ? {ID_W{1'b1}} : s;
    endfunction

    // One payload byte: present bytes compare under the mask, absent bytes
    // mismatch on every unmasked bit.
    function automatic logic byte_ok(input logic present,
                                     input logic [BYTE_W-1:0] key,
                                     input logic [BYTE_W-1:0] msk,
                                     input logic [BYTE_W-1:0] dat);
        if (present)
            return ((key ^ dat) & ~msk) == '0;
        return (~msk) == '0;
    endfunction

    function automatic logic key_match(input flt_key_t key,
                                       input flt_key_t msk,
                                       input rx_frame_t fr);
        logic id_ok, p0, p1;
        id_ok = ((key.id ^ fr.id) & ~msk.id & id_span(fr.ide)) == '0;
        p0    = !fr.rtr && (fr.dlc > 4'd0);
        p1    = !fr.rtr && (fr.dlc > 4'd1);
        return (key.ide == fr.ide) && id_ok &&
               byte_ok(p0, key.b0, msk.b0, fr.b0) &&
               byte_ok(p1, key.b1, msk.b1, fr.b1);
    endfunction

endpackage

// File: rtl/can_flt_slot.sv
module can_flt_slot
    import can_acc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      init_mode,
    input  logic      sel,
    input  logic      wr_mask,
    input  flt_key_t  wr_word,
    input  rx_frame_t frm,
    output logic      hit
);

    flt_key_t key_q;
    flt_key_t msk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            key_q <= '0;
            msk_q <= '0;
        end else if (sel && init_mode) begin
            if (wr_mask) msk_q <= wr_word;
            else         key_q <= wr_word;
        end
    end

    always_comb hit = key_match(key_q, msk_q, frm);

    // R11: slot contents frozen outside initialization mode
    a_r11_slot_locked: assert property (@(posedge clk) disable iff (rst)
        !init_mode |=> ($stable(key_q) && $stable(msk_q)));

endmodule

// File: rtl/can_rx_fifo.sv
module can_rx_fifo
    import can_acc_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             pop,
    input  rx_frame_t        din,
    output rx_frame_t        dout,
    output logic [CNT_W-1:0] cnt,
    output logic             full,
    output logic             empty
);

    rx_frame_t        mem [DEPTH];
    logic [PTR_W-1:0] wp, rp;
    logic             do_push, do_pop;

    always_comb begin
        full    = (cnt == CNT_W'(DEPTH));
        empty   = (cnt == '0);
        do_push = push && !full;
        do_pop  = pop && !empty;
        dout    = mem[rp];
    end

    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= nxt(wp);
            if (do_pop)  rp <= nxt(rp);
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                mem[i] <= '0;
            else if (do_push && wp == PTR_W'(i))
                mem[i] <= din;
        end
    end

    // R7: occupancy never exceeds the depth
    a_r7_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(DEPTH));

    // R7: a lone push grows the queue by one
    a_r7_push_grows: assert property (@(posedge clk) disable iff (rst)
        (push && !full && !pop) |=> cnt == $past(cnt) + 1'b1);

    // R8: a full queue without a pop keeps its size
    a_r8_full_holds: assert property (@(posedge clk) disable iff (rst)
        (full && !pop) |=> full);

endmodule

// File: rtl/can_accept_bank.sv
module can_accept_bank
    import can_acc_pkg::*;
#(
    parameter int NFILT = 8,
    parameter int DEPTH = 8,
    localparam int IDX_W = (NFILT > 1) ? $clog2(NFILT) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
)(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  init_mode,
    input  logic                  cfg_we,
    input  logic [IDX_W-1:0]      cfg_idx,
    input  logic                  cfg_mask_sel,
    input  logic [KEY_W-1:0]      cfg_word,
    input  logic                  filt_en,
    input  logic                  frm_valid,
    input  logic [FRAME_W-1:0]    frm_i,
    input  logic                  rd_pop,
    input  logic                  ovf_clr,
    output logic                  acc_o,
    output logic                  push_o,
    output logic [NFILT-1:0]      hit_o,
    output logic                  ovf_o,
    output logic [CNT_W-1:0]      fifo_cnt_o,
    output logic                  rd_valid_o,
    output logic [FRAME_W-1:0]    rd_frame_o,
    output logic                  tmp_valid_o,
    output logic [FRAME_W-1:0]    tmp_frame_o
);

    rx_frame_t        frm;
    flt_key_t         wkey;
    logic [NFILT-1:0] hit_c;
    dec_e             dec;
    logic             fifo_full, fifo_empty;
    rx_frame_t        head;
    rx_frame_t        tmp_q;

    always_comb begin
        frm  = rx_frame_t'(frm_i);
        wkey = flt_key_t'(cfg_word);
    end

    for (genvar k = 0; k < NFILT; k++) begin : g_flt
        can_flt_slot u_slot (
            .clk       (clk),
            .rst       (rst),
            .init_mode (init_mode),
            .sel       (cfg_we && cfg_idx == IDX_W'(k)),
            .wr_mask   (cfg_mask_sel),
            .wr_word   (wkey),
            .frm       (frm),
            .hit       (hit_c[k])
        );
    end

    always_comb begin
        if (!frm_valid)                  dec = DEC_IDLE;
        else if (filt_en && hit_c == '0) dec = DEC_REJECT;
        else if (fifo_full)              dec = DEC_DROP_FULL;
        else                             dec = DEC_STORE;
    end

    can_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (dec == DEC_STORE),
        .pop   (rd_pop),
        .din   (frm),
        .dout  (head),
        .cnt   (fifo_cnt_o),
        .full  (fifo_full),
        .empty (fifo_empty)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_o       <= 1'b0;
            push_o      <= 1'b0;
            hit_o       <= '0;
            ovf_o       <= 1'b0;
            tmp_valid_o <= 1'b0;
            tmp_q       <= '0;
        end else begin
            acc_o  <= (dec == DEC_STORE) || (dec == DEC_DROP_FULL);
            push_o <= (dec == DEC_STORE);
            hit_o  <= frm_valid ? hit_c : '0;
            if (dec == DEC_DROP_FULL) ovf_o <= 1'b1;
            else if (ovf_clr)         ovf_o <= 1'b0;
            if (frm_valid) begin
                tmp_q       <= frm;
                tmp_valid_o <= 1'b1;
            end
        end
    end

    always_comb begin
        rd_valid_o  = !fifo_empty;
        rd_frame_o  = head;
        tmp_frame_o = tmp_q;
    end

    // R3: filtering off accepts every strobed frame
    a_r3_pass_all: assert property (@(posedge clk) disable iff (rst)
        (frm_valid && !filt_en) |=> acc_o);

    // R4: with filtering on, no matching slot means rejection
    a_r4_no_hit_reject: assert property (@(posedge clk) disable iff (rst)
        (frm_valid && filt_en && hit_c == '0) |=> (!acc_o && !push_o));

    // R8: accepted frame on a full queue is dropped and flags overflow
    a_r8_drop_full: assert property (@(posedge clk) disable iff (rst)
        (frm_valid && !filt_en && fifo_cnt_o == CNT_W'(DEPTH)) |=> (!push_o && ovf_o));

    // R9: a clear with no drop in the same cycle lowers the flag
    a_r9_clear: assert property (@(posedge clk) disable iff (rst)
        (ovf_clr && !(frm_valid && fifo_full)) |=> !ovf_o);

    // R10: latest-frame buffer follows every strobe
    a_r10_tmp_capture: assert property (@(posedge clk) disable iff (rst)
        frm_valid |=> (tmp_valid_o && tmp_frame_o == $past(frm_i)));

    // R12: decision pulses only follow a strobe
    a_r12_pulse: assert property (@(posedge clk) disable iff (rst)
        !frm_valid |=> (!acc_o && !push_o && hit_o == '0));

endmodule

// File: tb/sim_can_accept_bank.sv
module sim_can_accept_bank;
    import can_acc_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        init_mode = 1'b0, cfg_we = 1'b0, cfg_mask_sel = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic [45:0] cfg_word = '0;
    logic        filt_en = 1'b0, frm_valid = 1'b0, rd_pop = 1'b0, ovf_clr = 1'b0;
    logic [50:0] frm_i = '0;
    logic        acc_o, push_o, ovf_o, rd_valid_o, tmp_valid_o;
    logic [7:0]  hit_o;
    logic [3:0]  fifo_cnt_o;
    logic [50:0] rd_frame_o, tmp_frame_o;

    int n_chk = 0, n_err = 0;

    always #2.5 clk = ~clk;

    can_accept_bank u0 (.*);

    function automatic logic [50:0] mkf(logic ide, logic rtr, logic [28:0] id,
                                        logic [3:0] dlc, logic [7:0] b0, logic [7:0] b1);
        return {ide, rtr, id, dlc, b0, b1};
    endfunction

    function automatic logic [45:0] mkk(logic ide, logic [28:0] id, logic [7:0] b0, logic [7:0] b1);
        return {ide, id, b0, b1};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wcfg(input logic [2:0] idx, input logic msk, input logic [45:0] w);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = idx; cfg_mask_sel = msk; cfg_word = w;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Strobe one frame; outputs are checked at the following falling edge.
    task automatic send(input logic [50:0] f, input logic pop, input logic clr);
        @(negedge clk);
        frm_valid = 1'b1; frm_i = f; rd_pop = pop; ovf_clr = clr;
        @(negedge clk);
        frm_valid = 1'b0; rd_pop = 1'b0; ovf_clr = 1'b0;
    endtask

    task automatic pop1;
        @(negedge clk);
        rd_pop = 1'b1;
        @(negedge clk);
        rd_pop = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 cnt", fifo_cnt_o, 0);
        chk("R1 rd_valid", rd_valid_o, 0);
        chk("R1 acc/push/ovf", {acc_o, push_o, ovf_o}, 0);
        chk("R1 hit", hit_o, 0);
        chk("R1 tmp_valid", tmp_valid_o, 0);
    endtask

    task automatic t_program;
        init_mode = 1'b1;
        wcfg(3'd0, 1'b0, mkk(1'b0, 29'h123, 8'h00, 8'h00));
        wcfg(3'd0, 1'b1, mkk(1'b0, 29'h0, 8'hFF, 8'hFF));
        wcfg(3'd1, 1'b0, mkk(1'b1, 29'h1ABCDE00, 8'h00, 8'h00));
        wcfg(3'd1, 1'b1, mkk(1'b0, 29'h000000FF, 8'hFF, 8'hFF));
        wcfg(3'd2, 1'b0, mkk(1'b0, 29'h055, 8'hA5, 8'h3C));
        wcfg(3'd3, 1'b0, mkk(1'b1, 29'h1FFFFFFF, 8'h00, 8'h00));
        init_mode = 1'b0;
    endtask

    task automatic t_filter;
        filt_en = 1'b1;
        send(mkf(0, 0, 29'h123, 4'd0, 8'h00, 8'h00), 0, 0);
        chk("R12 acc pulse", acc_o, 1);
        chk("R4 hit slot0", hit_o, 8'h01);
        chk("R6 masked absent bytes", push_o, 1);
        @(negedge clk);
        chk("R12 pulse one cycle", acc_o, 0);
        send(mkf(0, 0, 29'h124, 4'd0, 8'h00, 8'h00), 0, 0);
        chk("R2 unmasked id bit differs", {acc_o, push_o}, 2'b00);
        send(mkf(1, 0, 29'h1ABCDE5A, 4'd8, 8'h11, 8'h22), 0, 0);
        chk("R2 masked low id bits", hit_o, 8'h02);
        send(mkf(1, 0, 29'h123, 4'd0, 8'h00, 8'h00), 0, 0);
        chk("R5 ide mismatch rejects", acc_o, 0);
        send(mkf(0, 0, 29'h2923, 4'd0, 8'h00, 8'h00), 0, 0);
        chk("R5 std ignores id[28:11]", hit_o, 8'h01);
        send(mkf(0, 0, 29'h055, 4'd2, 8'hA5, 8'h3C), 0, 0);
        chk("R6 two present bytes match", hit_o, 8'h04);
        send(mkf(0, 0, 29'h055, 4'd1, 8'hA5, 8'h3C), 0, 0);
        chk("R6 dlc1 missing byte1", acc_o, 0);
        send(mkf(0, 1, 29'h055, 4'd2, 8'hA5, 8'h3C), 0, 0);
        chk("R6 remote frame no bytes", acc_o, 0);
        chk("R10 rejected frame captured", tmp_frame_o, mkf(0, 1, 29'h055, 4'd2, 8'hA5, 8'h3C));
        chk("R10 tmp valid", tmp_valid_o, 1);
        chk("R7 count after four stores", fifo_cnt_o, 4);
        chk("R7 oldest first", rd_frame_o, mkf(0, 0, 29'h123, 4'd0, 8'h00, 8'h00));
        pop1;
        chk("R7 next oldest", rd_frame_o, mkf(1, 0, 29'h1ABCDE5A, 4'd8, 8'h11, 8'h22));
        for (int i = 0; i < 3; i++) pop1;
        chk("R7 drained", rd_valid_o, 0);
    endtask

    task automatic t_passall;
        filt_en = 1'b0;
        send(mkf(0, 0, 29'h124, 4'd0, 8'h00, 8'h00), 0, 0);
        chk("R3 filter off accepts", {acc_o, push_o}, 2'b11);
        chk("R4 hit vector kept when off", hit_o, 8'h00);
        pop1;
    endtask

    task automatic t_lock;
        wcfg(3'd0, 1'b0, mkk(1'b0, 29'h124, 8'h00, 8'h00));
        wcfg(3'd0, 1'b1, mkk(1'b0, 29'h7FF, 8'hFF, 8'hFF));
        filt_en = 1'b1;
        send(mkf(0, 0, 29'h124, 4'd0, 8'h00, 8'h00), 0, 0);
        chk("R11 write outside init ignored", acc_o, 0);
        send(mkf(0, 0, 29'h123, 4'd0, 8'h00, 8'h00), 0, 0);
        chk("R11 old key still active", hit_o, 8'h01);
        pop1;
    endtask

    task automatic t_full;
        filt_en = 1'b0;
        for (int i = 0; i < 8; i++)
            send(mkf(0, 0, 29'(i), 4'd2, 8'(i), 8'h00), 0, 0);
        chk("R7 full count", fifo_cnt_o, 8);
        send(mkf(0, 0, 29'h100, 4'd2, 8'h00, 8'h00), 0, 0);
        chk("R8 dropped no push", {acc_o, push_o}, 2'b10);
        chk("R9 overflow set", ovf_o, 1);
        chk("R8 head kept", rd_frame_o, mkf(0, 0, 29'd0, 4'd2, 8'd0, 8'h00));
        send(mkf(0, 0, 29'h101, 4'd2, 8'h00, 8'h00), 1, 0);
        chk("R8 pop same cycle gives no room", push_o, 0);
        chk("R8 count after pop", fifo_cnt_o, 7);
        for (int i = 1; i < 8; i++) begin
            chk("R8 order preserved", rd_frame_o, mkf(0, 0, 29'(i), 4'd2, 8'(i), 8'h00));
            pop1;
        end
        chk("R8 empty after drain", rd_valid_o, 0);
        for (int i = 0; i < 8; i++)
            send(mkf(0, 0, 29'(i), 4'd0, 8'h00, 8'h00), 0, 0);
        send(mkf(0, 0, 29'h102, 4'd0, 8'h00, 8'h00), 0, 1);
        chk("R9 set wins over clear", ovf_o, 1);
        @(negedge clk);
        ovf_clr = 1'b1;
        @(negedge clk);
        ovf_clr = 1'b0;
        chk("R9 cleared by host", ovf_o, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_program;
        t_filter;
        t_passall;
        t_lock;
        t_full;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule